// File: doc/BRIEF.md
# RGMII Transmit Clock Generator

This block produces the transmit clock that a MAC drives toward an external RGMII PHY. Its settings come from a 32-bit control word. One field picks which of two parent sources feeds the chain. A second field holds a one-based divide ratio, which is meant to bring the parent down to about 250 MHz. A fixed halving stage always follows that divider. Another field gates the output, and a two-bit field adds a small phase delay. The halved clock is nominally 125 MHz. The block lowers it further according to the link-speed code: 125 MHz at gigabit, 25 MHz at 100 Mbit/s and 2.5 MHz at 10 Mbit/s.

The design is synthesizable. Every stage is built as a counter or a toggle clocked by one fast reference clock, and that reference stands in for the parent. When the alternate parent is selected, `alt_src_en` acts as a per-cycle enable that marks the edges of that parent. All settings except the ignored bits are captured together at the start of an output period. A setting changed in the middle of a period therefore never cuts a pulse short.

Top module: `rgmii_txc_gen`

## Requirements
- R1: With control bits 9:7 set to N (1..7) and the primary parent selected (bit 4 = 0), the divided tick occurs every N reference cycles. At gigabit speed, txc is high for N cycles out of a period of 2N cycles.
- R2: A divide field of 0 behaves exactly like a divide field of 1 (period of 2 cycles at gigabit).
- R3: A fixed halving stage follows the divider, so the output period is always an even multiple of the divided tick spacing. At gigabit speed the output is half the divided rate, with equal high and low times.
- R4: Speed code 2'b10 (and the unused code 2'b11) gives a ratio of 1 after the halving stage. Code 2'b01 divides by a further 5 and code 2'b00 by a further 50. With divide field N, txc is high for N*R cycles of a 2*N*R cycle period.
- R5: With bit 4 = 1, the chain advances only on cycles where alt_src_en is high. With bit 4 = 0, alt_src_en has no effect on txc.
- R6: With bit 10 = 0, txc stays low from the next period boundary onward. With bit 10 = 1, the clock runs.
- R7: Bits 6:5 set to D (0..3) delay every txc edge by D extra reference cycles.
- R8: New divide, select, speed, gate and delay settings take effect only at the start of an output period (the rising edge of the undelayed clock). The period in progress completes with the old settings, so no runt high or low segment appears.
- R9: While rst_n is low, txc is low. Bits 31:11 and 3:0 of the control word are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Fast reference clock, standing in for the primary parent |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| alt_src_en | input | 1 | Per-cycle edge enable of the alternate parent |
| ctrl_reg | input | 32 | Control word: bit 4 parent select, 6:5 delay, 9:7 divide, 10 gate |
| link_speed | input | 2 | Link speed code: 10 gigabit, 01 100 Mbit/s, 00 10 Mbit/s |
| txc | output | 1 | RGMII transmit clock to the PHY |

## Verification
The bound checker watches the internal stages on every cycle and checks four things:
- The halving and speed stage toggles only on a divided tick.
- Back-to-back divided ticks happen only with a divide ratio of one.
- Latched settings change only at a period start or at the first load after reset.
- txc is the gated clock delayed by exactly the latched tap count, stays low once the gate has been off for several cycles, and is low during reset.

Exact high times and periods for each divide, speed and parent combination can only be shown by the bench, which measures them at the pins. The same holds for the absence of runt segments when settings change in the middle of a period, and for the relative edge shift of each delay setting.

// File: rtl/rgmii_txc_pkg.sv
package rgmii_txc_pkg;

  // control word field positions (decoded by the configuration stage)
  localparam int unsigned SEL_BIT   = 4;
  localparam int unsigned DLY_LSB   = 5;
  localparam int unsigned DLY_W     = 2;
  localparam int unsigned DIV_LSB   = 7;
  localparam int unsigned DIV_W     = 3;
  localparam int unsigned GATE_BIT  = 10;

  // rate reduction after the halving stage, per link speed
  localparam int unsigned RATIO_GIG  = 1;
  localparam int unsigned RATIO_FAST = 5;
  localparam int unsigned RATIO_SLOW = 50;
  localparam int unsigned RATIO_W    = $clog2(RATIO_SLOW + 1);

  typedef enum logic [1:0] {
    SPD_10M  = 2'b00,
    SPD_100M = 2'b01,
    SPD_1G   = 2'b10,
    SPD_RSV  = 2'b11
  } link_speed_e;

  function automatic logic [RATIO_W-1:0] speed_ratio(input logic [1:0] code);
    logic [RATIO_W-1:0] r;
    case (link_speed_e'(code))
      SPD_10M:  r = RATIO_W'(RATIO_SLOW);
      SPD_100M: r = RATIO_W'(RATIO_FAST);
      default:  r = RATIO_W'(RATIO_GIG);
    endcase
    return r;
  endfunction

endpackage

// File: rtl/rgmii_txc_rst_sync.sv
module rgmii_txc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) sync_q <= '0;
    else              sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/rgmii_txc_cfg.sv
module rgmii_txc_cfg #(
  parameter int unsigned DIV_W   = 3,
  parameter int unsigned DLY_W   = 2,
  parameter int unsigned RATIO_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               period_start,
  input  logic               sel_in,
  input  logic [DLY_W-1:0]   dly_in,
  input  logic [DIV_W-1:0]   div_in,
  input  logic               gate_in,
  input  logic [RATIO_W-1:0] ratio_in,
  output logic               pend,
  output logic               sel_act,
  output logic [DLY_W-1:0]   dly_act,
  output logic [DIV_W-1:0]   div_act,
  output logic               gate_act,
  output logic [RATIO_W-1:0] ratio_act
);

  logic               load;
  logic               pend_d;
  logic               sel_d;
  logic [DLY_W-1:0]   dly_d;
  logic [DIV_W-1:0]   div_d;
  logic               gate_d;
  logic [RATIO_W-1:0] ratio_d;

  // first load right after reset, then only at period starts (R8)
  assign load = pend | period_start;

  always_comb begin
    pend_d  = 1'b0;
    sel_d   = sel_act;
    dly_d   = dly_act;
    div_d   = div_act;
    gate_d  = gate_act;
    ratio_d = ratio_act;
    if (load) begin
      sel_d   = sel_in;
      dly_d   = dly_in;
      div_d   = div_in;
      gate_d  = gate_in;
      ratio_d = ratio_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend      <= 1'b1;
      sel_act   <= 1'b0;
      dly_act   <= '0;
      div_act   <= DIV_W'(1);
      gate_act  <= 1'b0;
      ratio_act <= RATIO_W'(1);
    end else begin
      pend      <= pend_d;
      sel_act   <= sel_d;
      dly_act   <= dly_d;
      div_act   <= div_d;
      gate_act  <= gate_d;
      ratio_act <= ratio_d;
    end
  end

endmodule

// File: rtl/rgmii_txc_div.sv
module rgmii_txc_div #(
  parameter int unsigned DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_en,
  input  logic [DIV_W-1:0] div_act,
  output logic             div_tick
);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_d;
  logic [DIV_W-1:0] n_eff;
  logic             at_last;

  // one-based ratio; zero folded onto one (R1, R2)
  assign n_eff   = (div_act == '0) ? DIV_W'(1) : div_act;
  assign at_last = (cnt_q == n_eff - 1'b1);
  assign div_tick = src_en & at_last;

  always_comb begin
    cnt_d = cnt_q;
    if (src_en) begin
      if (at_last) cnt_d = '0;
      else         cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/rgmii_txc_toggle.sv
module rgmii_txc_toggle #(
  parameter int unsigned RATIO_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               div_tick,
  input  logic [RATIO_W-1:0] ratio_act,
  output logic               lvl,
  output logic               period_start
);

  logic [RATIO_W-1:0] rcnt_q;
  logic [RATIO_W-1:0] rcnt_d;
  logic [RATIO_W-1:0] r_eff;
  logic               lvl_d;
  logic               at_last;

  // Halving with speed reduction: the level flips every R divided ticks,
  // so one period spans 2*R ticks (R3, R4).
  assign r_eff   = (ratio_act == '0) ? RATIO_W'(1) : ratio_act;
  assign at_last = (rcnt_q == r_eff - 1'b1);
  assign period_start = div_tick & at_last & ~lvl;

  always_comb begin
    rcnt_d = rcnt_q;
    lvl_d  = lvl;
    if (div_tick) begin
      if (at_last) begin
        rcnt_d = '0;
        lvl_d  = ~lvl;
      end else begin
        rcnt_d = rcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcnt_q <= '0;
      lvl    <= 1'b0;
    end else begin
      rcnt_q <= rcnt_d;
      lvl    <= lvl_d;
    end
  end

endmodule

// File: rtl/rgmii_txc_delay.sv
module rgmii_txc_delay #(
  parameter int unsigned DLY_W = 2,
  localparam int unsigned TAPS = 2 ** DLY_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             d_in,
  input  logic [DLY_W-1:0] dly_act,
  output logic             q_out
);

  logic [TAPS-2:0] hist_q;
  logic [TAPS-2:0] hist_d;
  logic [TAPS-1:0] tap;
  logic            q_d;

  always_comb begin
    hist_d[0] = d_in;
    for (int i = 1; i < TAPS - 1; i++) hist_d[i] = hist_q[i-1];
  end

  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    if (k == 0) begin : g_direct
      assign tap[k] = d_in;
    end else begin : g_hist
      assign tap[k] = hist_q[k-1];
    end
  end

  // registered output: edges shift by dly_act extra cycles (R7)
  assign q_d = tap[dly_act];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      q_out  <= 1'b0;
    end else begin
      hist_q <= hist_d;
      q_out  <= q_d;
    end
  end

endmodule

// File: rtl/rgmii_txc_gen.sv
module rgmii_txc_gen
  import rgmii_txc_pkg::*;
#(
  parameter int unsigned CTRL_W = 32
) (
  input  logic              clk_ref,
  input  logic              rst_n,
  input  logic              alt_src_en,
  input  logic [CTRL_W-1:0] ctrl_reg,
  input  logic [1:0]        link_speed,
  output logic              txc
);

  logic               rst_sync_n;
  logic               cfg_pend;
  logic               sel_act;
  logic [DLY_W-1:0]   dly_act;
  logic [DIV_W-1:0]   div_act;
  logic               gate_act;
  logic [RATIO_W-1:0] ratio_act;
  logic               src_en;
  logic               div_tick;
  logic               lvl;
  logic               period_start;
  logic               gated;
  logic               unused_ctrl;

  // bits outside the decoded fields carry no function (R9)
  assign unused_ctrl = ^{ctrl_reg[CTRL_W-1:GATE_BIT+1], ctrl_reg[SEL_BIT-1:0]};

  rgmii_txc_rst_sync #(.STAGES(2)) u_rst (
    .clk         (clk_ref),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_sync_n)
  );

  rgmii_txc_cfg #(.DIV_W(DIV_W), .DLY_W(DLY_W), .RATIO_W(RATIO_W)) u_cfg (
    .clk          (clk_ref),
    .rst_n        (rst_sync_n),
    .period_start (period_start),
    .sel_in       (ctrl_reg[SEL_BIT]),
    .dly_in       (ctrl_reg[DLY_LSB +: DLY_W]),
    .div_in       (ctrl_reg[DIV_LSB +: DIV_W]),
    .gate_in      (ctrl_reg[GATE_BIT]),
    .ratio_in     (speed_ratio(link_speed)),
    .pend         (cfg_pend),
    .sel_act      (sel_act),
    .dly_act      (dly_act),
    .div_act      (div_act),
    .gate_act     (gate_act),
    .ratio_act    (ratio_act)
  );

  // parent select: primary advances every cycle, alternate on its enable (R5)
  assign src_en = (sel_act ? alt_src_en : 1'b1) & ~cfg_pend;

  rgmii_txc_div #(.DIV_W(DIV_W)) u_div (
    .clk      (clk_ref),
    .rst_n    (rst_sync_n),
    .src_en   (src_en),
    .div_act  (div_act),
    .div_tick (div_tick)
  );

  rgmii_txc_toggle #(.RATIO_W(RATIO_W)) u_tog (
    .clk          (clk_ref),
    .rst_n        (rst_sync_n),
    .div_tick     (div_tick),
    .ratio_act    (ratio_act),
    .lvl          (lvl),
    .period_start (period_start)
  );

  // gate latched at the period start, so it never clips a pulse (R6)
  assign gated = lvl & gate_act;

  rgmii_txc_delay #(.DLY_W(DLY_W)) u_dly (
    .clk     (clk_ref),
    .rst_n   (rst_sync_n),
    .d_in    (gated),
    .dly_act (dly_act),
    .q_out   (txc)
  );

endmodule

// File: rtl/rgmii_txc_chk.sv
module rgmii_txc_chk #(
  parameter int unsigned DIV_W   = 3,
  parameter int unsigned DLY_W   = 2,
  parameter int unsigned RATIO_W = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               txc,
  input logic               div_tick,
  input logic               lvl,
  input logic               gated,
  input logic               gate_act,
  input logic               pend,
  input logic               sel_act,
  input logic [DLY_W-1:0]   dly_act,
  input logic [DIV_W-1:0]   div_act,
  input logic [RATIO_W-1:0] ratio_act
);

  // R9: output low while reset is applied
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_r9_reset_low: assert (!txc);
    end
  end

  // R3: the halving stage moves only on a divided tick
  a_r3_toggle_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lvl) |-> $past(div_tick));

  // R1: consecutive ticks only with a ratio of one
  a_r1_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    div_tick |=> (!div_tick || div_act <= DIV_W'(1)));

  // R8: latched settings change only at a period start or first load
  a_r8_cfg_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({div_act, ratio_act, sel_act, gate_act, dly_act}) |-> ($rose(lvl) || $past(pend)));

  // R6: gate off for several cycles keeps the pin low
  a_r6_gate_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_act && $past(!gate_act) && $past(!gate_act, 2) && $past(!gate_act, 3)
     && $past(!gate_act, 4)) |-> !txc);

  // R7: pin equals the gated clock delayed by the tap count plus one register
  a_r7_delay_tap0: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(dly_act) == DLY_W'(0)) |-> (txc == $past(gated, 1)));
  a_r7_delay_tap1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(dly_act) == DLY_W'(1)) |-> (txc == $past(gated, 2)));
  a_r7_delay_tap2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(dly_act) == DLY_W'(2)) |-> (txc == $past(gated, 3)));
  a_r7_delay_tap3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(dly_act) == DLY_W'(3)) |-> (txc == $past(gated, 4)));

endmodule

bind rgmii_txc_gen rgmii_txc_chk #(
  .DIV_W   (rgmii_txc_pkg::DIV_W),
  .DLY_W   (rgmii_txc_pkg::DLY_W),
  .RATIO_W (rgmii_txc_pkg::RATIO_W)
) u_chk (
  .clk       (clk_ref),
  .rst_n     (rst_sync_n),
  .txc       (txc),
  .div_tick  (div_tick),
  .lvl       (lvl),
  .gated     (gated),
  .gate_act  (gate_act),
  .pend      (cfg_pend),
  .sel_act   (sel_act),
  .dly_act   (dly_act),
  .div_act   (div_act),
  .ratio_act (ratio_act)
);

// File: tb/tb_rgmii_txc_gen.sv
`timescale 1ns/1ps
module tb_rgmii_txc_gen;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        alt_src_en;
  logic [31:0] ctrl_reg;
  logic [1:0]  link_speed;
  logic        txc;
  logic        alt_mode;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  rgmii_txc_gen dut (
    .clk_ref    (clk_ref_w),
    .rst_n      (rst_n),
    .alt_src_en (alt_src_en),
    .ctrl_reg   (ctrl_reg),
    .link_speed (link_speed),
    .txc        (txc)
  );

  wire clk_ref_w = clk;

  // alternate parent edge enable: steady high or one cycle in two
  initial begin
    alt_src_en = 1'b1;
    forever begin
      @(negedge clk);
      alt_src_en = alt_mode ? ~alt_src_en : 1'b1;
    end
  end

  // bit 4 select, 6:5 delay, 9:7 divide, 10 gate; other bits filled with junk (R9)
  function automatic logic [31:0] mk(input logic sel, input logic [1:0] dly,
                                     input logic [2:0] dv, input logic gate);
    logic [31:0] w;
    w = 32'hA5A5_F80F;
    w[4] = sel;
    w[6:5] = dly;
    w[9:7] = dv;
    w[10] = gate;
    return w;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_rise();
    logic p;
    p = txc;
    @(negedge clk);
    while (!( !p && txc)) begin
      p = txc;
      @(negedge clk);
    end
  endtask

  task automatic measure(output int hi, output int per);
    int lo;
    wait_rise();
    hi = 0;
    lo = 0;
    while (txc) begin hi++; @(negedge clk); end
    while (!txc) begin lo++; @(negedge clk); end
    per = hi + lo;
  endtask

  task automatic rate_case(input string tag, input logic sel, input logic [2:0] dv,
                           input logic [1:0] spd, input int exp_hi, input int exp_per);
    int hi, per;
    ctrl_reg = mk(sel, 2'd0, dv, 1'b1);
    link_speed = spd;
    measure(hi, per);
    measure(hi, per);
    measure(hi, per);
    check(hi == exp_hi, {tag, " high time"}, hi, exp_hi);
    check(per == exp_per, {tag, " period"}, per, exp_per);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    ctrl_reg = mk(1'b0, 2'd0, 3'd2, 1'b1);
    link_speed = 2'b10;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(txc == 1'b0, "R9 txc low in reset", txc, 0);
    end
    rst_n = 1'b1;
  endtask

  task automatic t_divider();
    rate_case("R1 div 1 / R3 halving", 1'b0, 3'd1, 2'b10, 1, 2);
    rate_case("R1 div 3", 1'b0, 3'd3, 2'b10, 3, 6);
    rate_case("R1 div 7", 1'b0, 3'd7, 2'b10, 7, 14);
    rate_case("R2 div 0 as 1", 1'b0, 3'd0, 2'b10, 1, 2);
  endtask

  task automatic t_speed();
    rate_case("R4 100M", 1'b0, 3'd2, 2'b01, 10, 20);
    rate_case("R4 10M", 1'b0, 3'd2, 2'b00, 100, 200);
    rate_case("R4 code 11 as gigabit", 1'b0, 3'd2, 2'b11, 2, 4);
    rate_case("R4 gigabit", 1'b0, 3'd2, 2'b10, 2, 4);
  endtask

  task automatic t_parent();
    alt_mode = 1'b1;
    rate_case("R5 primary ignores alt enable", 1'b0, 3'd2, 2'b10, 2, 4);
    rate_case("R5 alternate half-rate enable", 1'b1, 3'd2, 2'b10, 4, 8);
    alt_mode = 1'b0;
    rate_case("R5 alternate steady enable", 1'b1, 3'd2, 2'b10, 2, 4);
  endtask

  task automatic t_gate();
    int highs;
    ctrl_reg = mk(1'b0, 2'd0, 3'd2, 1'b0);
    link_speed = 2'b10;
    repeat (20) @(negedge clk);
    highs = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (txc) highs++;
    end
    check(highs == 0, "R6 gate off holds txc low", highs, 0);
    rate_case("R6 gate back on", 1'b0, 3'd2, 2'b10, 2, 4);
  endtask

  task automatic first_rise(input logic [1:0] d, output int t);
    @(negedge clk);
    rst_n = 1'b0;
    ctrl_reg = mk(1'b0, d, 3'd2, 1'b1);
    link_speed = 2'b10;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t = 0;
    while (!txc && t < 1000) begin
      @(negedge clk);
      t++;
    end
  endtask

  task automatic t_delay();
    int t0, t1, t2, t3;
    first_rise(2'd0, t0);
    first_rise(2'd1, t1);
    first_rise(2'd2, t2);
    first_rise(2'd3, t3);
    check(t1 - t0 == 1, "R7 delay 1", t1 - t0, 1);
    check(t2 - t0 == 2, "R7 delay 2", t2 - t0, 2);
    check(t3 - t0 == 3, "R7 delay 3", t3 - t0, 3);
  endtask

  task automatic t_boundary();
    int hi, per, len, bad;
    int seg [16];
    logic lev;
    ctrl_reg = mk(1'b0, 2'd0, 3'd4, 1'b1);
    link_speed = 2'b10;
    measure(hi, per);
    measure(hi, per);
    wait_rise();
    @(negedge clk);
    ctrl_reg = mk(1'b0, 2'd0, 3'd1, 1'b1);
    for (int s = 0; s < 16; s++) begin
      lev = txc;
      len = 0;
      while (txc == lev) begin len++; @(negedge clk); end
      seg[s] = len;
    end
    bad = 0;
    for (int s = 1; s < 16; s++) if (seg[s] != 4 && seg[s] != 1) bad++;
    check(bad == 0, "R8 no runt segments", bad, 0);
    check(seg[1] == 4, "R8 period in progress keeps old ratio", seg[1], 4);
    check(seg[15] == 1, "R8 new ratio applied", seg[15], 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    alt_mode = 1'b0;
    rst_n = 1'b0;
    ctrl_reg = '0;
    link_speed = 2'b10;
    @(negedge clk);
    t_reset();
    t_divider();
    t_speed();
    t_parent();
    t_gate();
    t_boundary();
    t_delay();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule